// File: doc/BRIEF.md
# Round key expander

This block turns a secret key of 0 to 32 bytes into the table of 44 words of 32 bits that a 20-round, 128-bit block cipher core needs. Key bytes are written one at a time through an addressed byte port. The byte count is presented on `key_len` when `start` is pulsed. The block then works through two passes with no further input. The first pass fills the table from two fixed constants, one word per clock. The second pass mixes the key into the table, one iteration per clock.

A cipher core reads the finished table through a combinational index port. `busy` is high while the passes run. `done` pulses once when the table is ready. The raw key bytes stay stored, so the same key can be expanded again without reloading it.

Top module: `round_key_expander`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every table word reads as 0.
- R2: Key bytes are packed little-endian into key words: byte n lands in bits [8*(n%4)+7 : 8*(n%4)] of word n/4. Bytes at an address at or above `key_len` count as zero, whatever was written to them before. The word count c is ceil(key_len/4), and a zero-length key uses c=1 with a zero word.
- R3: The fill pass sets table word 0 to 0xB7E15163 and each later word k (1..43) to word k-1 plus 0x9E3779B9, modulo 2^32.
- R4: The mixing pass runs 3*max(c,44) iterations. Two accumulators X and Y, and two indices i and j, all start at 0. In each iteration, X becomes (T[i]+X+Y) rotated left by 3 and is written to T[i]. Y then becomes (K[j]+X+Y) rotated left, using the new X, and is written to K[j]. After that, i steps modulo 44 and j steps modulo c.
- R5: The variable rotation in R4 uses only the low 5 bits of X+Y as its amount.
- R6: Count the rising edge that samples `start` as edge 1. `busy` is high after edges 1 through 175. `done` is high for exactly the one cycle after edge 176, and `busy` is low from then on.
- R7: A `start` pulse while `busy` is high has no effect. The run in progress ends at the same edge and produces the same table.
- R8: Byte writes while `busy` is high are discarded. A later `start` with no new writes expands the previously stored key.
- R9: `rd_word` returns table word `rd_idx` in the same cycle. For `rd_idx` of 44 or more it returns 0.
- R10: While idle, the table keeps its contents unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Write strobe for one key byte |
| key_addr | input | 5 | Byte address, 0..31 |
| key_data | input | 8 | Key byte value |
| key_len | input | 6 | Key length in bytes (0..32), sampled with start |
| start | input | 1 | Begin expansion when idle |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle pulse when the table is ready |
| rd_idx | input | 6 | Table word index |
| rd_word | output | 32 | Table word at rd_idx |

## Verification
The hardest situation to reach from the ports is a `start` pulse and a burst of key writes that land in the middle of a run. Both must leave the run's length and its result untouched, and they must also leave the stored key intact for the next run. The stimulus injects a repeated `start` and a series of garbage byte writes during the fill and early mixing phases. It then checks the completion edge and the table of that run. Finally it starts a second run without rewriting the key and expects the table of the original key again. Masking of stale bytes is reached by first filling all 32 byte slots with 0xFF and then expanding a 5-byte key.

// File: rtl/rkx_pkg.sv
package rkx_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] SEED_BASE = 32'hB7E1_5163;
    localparam logic [WORD_W-1:0] SEED_STEP = 32'h9E37_79B9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_MIX
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
    } acc_t;

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v,
                                               input logic [4:0] n);
        return (v << n) | (v >> (6'd32 - {1'b0, n}));
    endfunction
endpackage

// File: rtl/rkx_keystore.sv
module rkx_keystore #(
    parameter int KEY_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [$clog2(KEY_BYTES)-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic              load,
    input  logic [$clog2(KEY_BYTES+1)-1:0] key_len,
    input  logic              mix_en,
    input  logic [((KEY_BYTES/4) > 1 ? $clog2(KEY_BYTES/4) : 1)-1:0] kidx,
    input  logic [31:0]       mix_wdata,
    output logic [31:0]       k_word
);
    localparam int NWORDS = KEY_BYTES / 4;

    logic [7:0]  byte_q [KEY_BYTES];
    logic [31:0] wrk_q  [NWORDS];
    logic [31:0] packed_w [NWORDS];

    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            for (int k = 0; k < 4; k++) begin
                packed_w[w][8*k +: 8] = ((w*4 + k) < int'(key_len)) ? byte_q[w*4 + k] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < KEY_BYTES; n++) byte_q[n] <= 8'h00;
            for (int w = 0; w < NWORDS; w++) wrk_q[w] <= '0;
        end else begin
            if (wr_en) byte_q[wr_addr] <= wr_byte;
            if (load) begin
                for (int w = 0; w < NWORDS; w++) wrk_q[w] <= packed_w[w];
            end else if (mix_en) begin
                wrk_q[kidx] <= mix_wdata;
            end
        end
    end

    assign k_word = wrk_q[kidx];
endmodule

// File: rtl/rkx_table.sv
module rkx_table
    import rkx_pkg::*;
#(
    parameter int TBL = 44
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fill_first,
    input  logic                    fill_step,
    input  logic                    mix_en,
    input  logic [$clog2(TBL)-1:0]  widx,
    input  logic [WORD_W-1:0]       mix_wdata,
    input  logic [$clog2(TBL)-1:0]  rd_idx,
    output logic [WORD_W-1:0]       cur_word,
    output logic [WORD_W-1:0]       rd_word
);
    logic [WORD_W-1:0] tbl_q [TBL];
    logic [WORD_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < TBL; n++) tbl_q[n] <= '0;
            run_q <= '0;
        end else if (fill_first) begin
            tbl_q[0] <= SEED_BASE;
            run_q    <= SEED_BASE + SEED_STEP;
        end else if (fill_step) begin
            tbl_q[widx] <= run_q;
            run_q       <= run_q + SEED_STEP;
        end else if (mix_en) begin
            tbl_q[widx] <= mix_wdata;
        end
    end

    assign cur_word = tbl_q[widx];
    assign rd_word  = (int'(rd_idx) < TBL) ? tbl_q[rd_idx] : '0;
endmodule

// File: rtl/rkx_mix.sv
module rkx_mix
    import rkx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              mix_en,
    input  logic [WORD_W-1:0] t_word,
    input  logic [WORD_W-1:0] k_word,
    output logic [WORD_W-1:0] t_new,
    output logic [WORD_W-1:0] k_new
);
    acc_t acc_q;
    acc_t acc_d;
    logic [WORD_W-1:0] xy_sum;

    always_comb begin
        acc_d.x = rotl(t_word + acc_q.x + acc_q.y, 5'd3);
        xy_sum  = acc_d.x + acc_q.y;
        acc_d.y = rotl(k_word + xy_sum, xy_sum[4:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else if (mix_en)  acc_q <= acc_d;
    end

    assign t_new = acc_d.x;
    assign k_new = acc_d.y;
endmodule

// File: rtl/rkx_ctrl.sv
module rkx_ctrl
    import rkx_pkg::*;
#(
    parameter int TBL       = 44,
    parameter int KEY_BYTES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic [$clog2(KEY_BYTES+1)-1:0] key_len,
    output logic accept,
    output logic fill_step,
    output logic mix_en,
    output logic [$clog2(TBL)-1:0] tidx,
    output logic [((KEY_BYTES/4) > 1 ? $clog2(KEY_BYTES/4) : 1)-1:0] kidx,
    output logic busy,
    output logic done
);
    localparam int NWORDS = KEY_BYTES / 4;
    localparam int KIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int TIW    = $clog2(TBL);
    localparam int MAXV   = (NWORDS > TBL) ? NWORDS : TBL;
    localparam int ITW    = $clog2(3*MAXV + 1);

    phase_e           ph_q;
    logic [TIW-1:0]   ti_q;
    logic [KIW-1:0]   kj_q;
    logic [KIW:0]     cw_q;
    logic [ITW-1:0]   it_q;
    logic [ITW-1:0]   lim_q;
    logic [KIW:0]     cw_d;
    logic [ITW-1:0]   lim_d;
    logic             last_it;

    always_comb begin
        int c;
        c = (int'(key_len) + 3) / 4;
        if (c == 0) c = 1;
        cw_d  = (KIW+1)'(c);
        lim_d = ITW'(((c > TBL) ? 3*c : 3*TBL) - 1);
    end

    assign accept    = start && (ph_q == ST_IDLE);
    assign fill_step = (ph_q == ST_FILL);
    assign mix_en    = (ph_q == ST_MIX);
    assign busy      = (ph_q != ST_IDLE);
    assign tidx      = ti_q;
    assign kidx      = kj_q;
    assign last_it   = mix_en && (it_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= ST_IDLE;
            ti_q  <= '0;
            kj_q  <= '0;
            cw_q  <= '0;
            it_q  <= '0;
            lim_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_it;
            unique case (ph_q)
                ST_IDLE: if (accept) begin
                    ph_q  <= ST_FILL;
                    ti_q  <= TIW'(1);
                    cw_q  <= cw_d;
                    lim_q <= lim_d;
                end
                ST_FILL: begin
                    if (ti_q == TIW'(TBL-1)) begin
                        ph_q <= ST_MIX;
                        ti_q <= '0;
                        kj_q <= '0;
                        it_q <= '0;
                    end else begin
                        ti_q <= ti_q + 1'b1;
                    end
                end
                ST_MIX: begin
                    ti_q <= (ti_q == TIW'(TBL-1)) ? '0 : ti_q + 1'b1;
                    kj_q <= ({1'b0, kj_q} == cw_q - 1'b1) ? '0 : kj_q + 1'b1;
                    it_q <= it_q + 1'b1;
                    if (last_it) ph_q <= ST_IDLE;
                end
                default: ph_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/round_key_expander.sv
module round_key_expander
    import rkx_pkg::*;
#(
    parameter int ROUNDS    = 20,
    parameter int KEY_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_we,
    input  logic [$clog2(KEY_BYTES)-1:0]   key_addr,
    input  logic [7:0]  key_data,
    input  logic [$clog2(KEY_BYTES+1)-1:0] key_len,
    input  logic        start,
    output logic        busy,
    output logic        done,
    input  logic [$clog2(2*ROUNDS+4)-1:0]  rd_idx,
    output logic [31:0] rd_word
);
    localparam int TBL    = 2*ROUNDS + 4;
    localparam int TIW    = $clog2(TBL);
    localparam int NWORDS = KEY_BYTES / 4;
    localparam int KIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic             accept;
    logic             fill_step;
    logic             mix_en;
    logic [TIW-1:0]   tidx;
    logic [KIW-1:0]   kidx;
    logic [WORD_W-1:0] t_word;
    logic [WORD_W-1:0] k_word;
    logic [WORD_W-1:0] t_new;
    logic [WORD_W-1:0] k_new;

    rkx_ctrl #(.TBL(TBL), .KEY_BYTES(KEY_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .key_len(key_len),
        .accept(accept), .fill_step(fill_step), .mix_en(mix_en),
        .tidx(tidx), .kidx(kidx), .busy(busy), .done(done)
    );

    rkx_keystore #(.KEY_BYTES(KEY_BYTES)) u_keys (
        .clk(clk), .rst(rst), .wr_en(key_we && !busy), .wr_addr(key_addr),
        .wr_byte(key_data), .load(accept), .key_len(key_len),
        .mix_en(mix_en), .kidx(kidx), .mix_wdata(k_new), .k_word(k_word)
    );

    rkx_table #(.TBL(TBL)) u_tbl (
        .clk(clk), .rst(rst), .fill_first(accept), .fill_step(fill_step),
        .mix_en(mix_en), .widx(tidx), .mix_wdata(t_new), .rd_idx(rd_idx),
        .cur_word(t_word), .rd_word(rd_word)
    );

    rkx_mix u_mix (
        .clk(clk), .rst(rst), .clear(accept), .mix_en(mix_en),
        .t_word(t_word), .k_word(k_word), .t_new(t_new), .k_new(k_new)
    );
endmodule

// File: rtl/round_key_expander_chk.sv
module round_key_expander_chk #(
    parameter int IDXW = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [IDXW-1:0] rd_idx,
    input logic [31:0]     rd_word
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R6
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));

    // R6
    busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

    // R7
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));

    // R10
    idle_table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && $stable(rd_idx)) |-> $stable(rd_word));
endmodule

bind round_key_expander round_key_expander_chk #(.IDXW($clog2(2*ROUNDS+4))) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_word(rd_word)
);

// File: tb/round_key_expander_bench.sv
`timescale 1ns/1ps
module round_key_expander_bench;
    localparam int TBL = 44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_we = 1'b0;
    logic [4:0]  key_addr = '0;
    logic [7:0]  key_data = '0;
    logic [5:0]  key_len = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_word;

    int total = 0;
    int bad = 0;

    logic [7:0]  ref_key [32];
    logic [31:0] exp_t [TBL];

    always #4 clk = ~clk;

    round_key_expander u_round_key_expander (
        .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr),
        .key_data(key_data), .key_len(key_len), .start(start),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    function automatic logic [31:0] rol(input logic [31:0] v, input int n);
        int m;
        m = n % 32;
        if (m == 0) return v;
        return (v << m) | (v >> (32 - m));
    endfunction

    // Reference: R2 packing, R3 fill, R4/R5 mixing
    task automatic build_expected(input int len);
        logic [31:0] kw [8];
        logic [31:0] x, y;
        int c, v, i, j;
        c = (len + 3) / 4;
        if (c == 0) c = 1;
        for (int w = 0; w < 8; w++) kw[w] = 32'h0;
        for (int n = 0; n < len; n++) kw[n/4] |= 32'(ref_key[n]) << (8*(n%4));
        exp_t[0] = 32'hB7E15163;
        for (int k = 1; k < TBL; k++) exp_t[k] = exp_t[k-1] + 32'h9E3779B9;
        x = 0; y = 0; i = 0; j = 0;
        v = 3 * ((c > TBL) ? c : TBL);
        for (int s = 0; s < v; s++) begin
            x = rol(exp_t[i] + x + y, 3);
            exp_t[i] = x;
            y = rol(kw[j] + x + y, int'((x + y) & 32'h1F));
            kw[j] = y;
            i = (i + 1) % TBL;
            j = (j + 1) % c;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_table(input string req);
        int miss;
        logic [31:0] a, e;
        miss = 0; a = 0; e = 0;
        for (int k = 0; k < TBL; k++) begin
            @(negedge clk);
            rd_idx = 6'(k);
            #1;
            if (rd_word !== exp_t[k] && miss == 0) begin
                a = rd_word; e = exp_t[k];
            end
            if (rd_word !== exp_t[k]) miss++;
        end
        check(miss == 0, req, a, e);
    endtask

    task automatic write_key(input int len, input logic [7:0] base);
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            key_we = 1'b1;
            key_addr = 5'(n);
            key_data = base + 8'(n * 37);
            ref_key[n] = key_data;
        end
        @(negedge clk);
        key_we = 1'b0;
    endtask

    // Runs one expansion; optionally injects start and key writes mid-run (R7, R8)
    task automatic do_run(input int len, input bit inject, input string req);
        int edges;
        bit busy_ok;
        key_len = 6'(len);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        busy_ok = busy;
        while (edges < 400) begin
            if (inject && edges >= 10 && edges < 60) begin
                start = (edges % 7 == 0);
                key_we = 1'b1;
                key_addr = 5'(edges % 32);
                key_data = 8'hA5;
            end else begin
                start = 1'b0;
                key_we = 1'b0;
            end
            @(negedge clk);
            edges++;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
        end
        start = 1'b0;
        key_we = 1'b0;
        check(edges == 176, {req, " R6 done edge"}, 32'(edges), 32'd176);
        check(busy_ok, {req, " R6 busy during run"}, 32'(busy_ok), 32'd1);
        @(negedge clk);
        check(!done && !busy, {req, " R6 done one cycle"}, {30'd0, done, busy}, 32'd0);
    endtask

    task automatic t_reset();
        int nz;
        nz = 0;
        check(!busy && !done, "R1 flags after reset", {30'd0, busy, done}, 32'd0);
        for (int k = 0; k < TBL; k++) begin
            rd_idx = 6'(k);
            #1;
            if (rd_word !== 32'h0) nz++;
        end
        check(nz == 0, "R1 table zero after reset", 32'(nz), 32'd0);
    endtask

    task automatic t_len(input int len, input logic [7:0] base, input string req);
        write_key(len, base);
        build_expected(len);
        do_run(len, 1'b0, req);
        check_table({req, " table"});
    endtask

    // R2: stale bytes above key_len must be masked
    task automatic t_mask();
        write_key(32, 8'hFF);
        for (int n = 0; n < 32; n++) ref_key[n] = 8'hFF;
        for (int n = 0; n < 32; n++) begin
            @(negedge clk);
            key_we = 1'b1; key_addr = 5'(n); key_data = 8'hFF;
        end
        @(negedge clk);
        key_we = 1'b0;
        write_key(5, 8'h11);
        build_expected(5);
        do_run(5, 1'b0, "R2 mask");
        check_table("R2 5-byte key table");
        build_expected(0);
        do_run(0, 1'b0, "R2 zero length");
        check_table("R2 zero-length key table");
    endtask

    // R7 and R8: start and key writes during busy are ignored
    task automatic t_busy_ignore();
        write_key(16, 8'h3C);
        build_expected(16);
        do_run(16, 1'b1, "R7 start during busy");
        check_table("R7 table unaffected by mid-run start");
        do_run(16, 1'b0, "R8 rerun");
        check_table("R8 stored key unchanged by busy writes");
    endtask

    // R9: out-of-range read returns zero
    task automatic t_range();
        int nz;
        nz = 0;
        for (int k = TBL; k < 64; k++) begin
            @(negedge clk);
            rd_idx = 6'(k);
            #1;
            if (rd_word !== 32'h0) nz++;
        end
        check(nz == 0, "R9 out-of-range read", 32'(nz), 32'd0);
    endtask

    // R10: table holds while idle, including across key writes
    task automatic t_hold();
        write_key(8, 8'h77);
        repeat (20) @(negedge clk);
        check_table("R10 table held while idle");
    endtask

    initial begin
        for (int n = 0; n < 32; n++) ref_key[n] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_len(16, 8'h01, "R4 16-byte");
        t_len(32, 8'h80, "R4 32-byte");
        t_len(24, 8'h5A, "R5 24-byte");
        t_mask();
        t_busy_ignore();
        t_range();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule